// File: doc/BRIEF.md
# Ones' Complement End-Around Adder

This block adds two operand words in ones' complement arithmetic, the form used by internet-style checksum datapaths. The carry that leaves the top bit is added back in at the bottom bit. This is the end-around carry. The block does not feed the carry-out of an adder straight back to its own carry-in, because that would form a combinational loop. Instead, a first adder produces a partial sum and its carry. A second adder then adds that carry into the partial sum.

The second stage cannot generate a carry of its own. Because of this, one pass across the full width always settles the result. When the answer is zero, it comes out as one fixed encoding, never a mix of the two.

The result, two zero-encoding flags and a valid strobe are registered one clock after the operands are presented. The operand width is a parameter, with 16 as the default.

Top module: `ones_comp_adder`

## Requirements
- R1: When `in_valid` is high, the registered `sum` equals the ones' complement sum of `op_a` and `op_b`. This is their binary sum with every carry out of bit WIDTH-1 folded back in at bit 0 until no carry remains, truncated to WIDTH bits.
- R2: `sum`, `pos_zero` and `neg_zero` are taken at the first rising clock edge where `in_valid` is high. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R3: A value added to its own bitwise complement yields all ones (negative zero).
- R4: All ones added to all ones yields all ones. All ones added to any nonzero value x yields x.
- R5: The all-zeros result (positive zero) appears only when both operands are all zeros. Every other zero-valued sum is reported as all ones.
- R6: When a result is taken, `pos_zero` is 1 exactly when that result is all zeros, and `neg_zero` is 1 exactly when it is all ones. The two flags are never high together.
- R7: In a cycle where `in_valid` is low, `sum`, `pos_zero` and `neg_zero` keep their previous values, whatever the operand inputs carry.
- R8: While `rst_n` is low, `sum`, `pos_zero`, `neg_zero` and `out_valid` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | WIDTH | First operand, ones' complement |
| op_b | input | WIDTH | Second operand, ones' complement |
| out_valid | output | 1 | A new result is present this cycle |
| sum | output | WIDTH | Registered ones' complement sum |
| pos_zero | output | 1 | Registered result is all zeros |
| neg_zero | output | 1 | Registered result is all ones |

## Verification
The bench targets the operand pairs that exercise the carry fold hardest.

- A value plus its complement has no carry. A design that forced zero to all zeros would return 0000 here instead of FFFF.
- All ones plus all ones carries out and then needs exactly one increment. A design that dropped the carry would return FFFE, and one that let a second carry wrap would return 0000.
- 8000 plus 8000 and FFFF plus 0001 have a partial sum of zero before the fold. A design missing the fold would return 0000 where 0001 is right.

The bench also sends idle cycles with changing operands, to catch registers that load without the strobe. Back-to-back strobes catch a valid output that lags or leads the result. A mid-run reset catches any register left out of the clear.

// File: rtl/oca_pkg.sv
package oca_pkg;

    // Classification of a result word with respect to the two zero encodings.
    typedef enum logic [1:0] {
        ZC_NONE = 2'd0,
        ZC_POS  = 2'd1,
        ZC_NEG  = 2'd2
    } zero_class_e;

    localparam int unsigned DEFAULT_WIDTH = 16;

endpackage

// File: rtl/oca_carry_stage.sv
// First adder: plain binary sum of the operands, split into a WIDTH-bit
// partial result and the carry out of the top bit.
module oca_carry_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    output logic [WIDTH-1:0] partial,
    output logic             carry
);
    localparam int unsigned FULLW = WIDTH + 1;

    logic [FULLW-1:0] full;

    always_comb begin
        full    = {1'b0, op_x} + {1'b0, op_y};
        partial = full[WIDTH-1:0];
        carry   = full[FULLW-1];
    end
endmodule

// File: rtl/oca_fold_stage.sv
// Second adder: adds the carry from the first stage in at bit 0.
// With a carry the partial sum is at most all-ones minus one, so this stage
// never produces a carry of its own.
module oca_fold_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] partial,
    input  logic             carry,
    output logic [WIDTH-1:0] folded
);
    logic [WIDTH-1:0] carry_word;

    always_comb begin
        carry_word = {{(WIDTH-1){1'b0}}, carry};
        folded     = partial + carry_word;
    end
endmodule

// File: rtl/oca_zero_detect.sv
// Classifies a word as positive zero, negative zero, or neither.
module oca_zero_detect
    import oca_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] value,
    output zero_class_e      cls
);
    logic all_clear;
    logic all_set;

    always_comb begin
        all_clear = ~|value;
        all_set   = &value;
        if (all_clear)    cls = ZC_POS;
        else if (all_set) cls = ZC_NEG;
        else              cls = ZC_NONE;
    end
endmodule

// File: rtl/ones_comp_adder.sv
module ones_comp_adder
    import oca_pkg::*;
#(
    parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             pos_zero,
    output logic             neg_zero
);
    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] res;
        logic             pz;
        logic             nz;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] partial;
    logic             carry;
    logic [WIDTH-1:0] folded;
    zero_class_e      cls;

    oca_carry_stage #(.WIDTH(WIDTH)) u_carry (
        .op_x    (op_a),
        .op_y    (op_b),
        .partial (partial),
        .carry   (carry)
    );

    oca_fold_stage #(.WIDTH(WIDTH)) u_fold (
        .partial (partial),
        .carry   (carry),
        .folded  (folded)
    );

    oca_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value (folded),
        .cls   (cls)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = folded;
            st_d.pz  = (cls == ZC_POS);
            st_d.nz  = (cls == ZC_NEG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign sum       = st_q.res;
    assign pos_zero  = st_q.pz;
    assign neg_zero  = st_q.nz;
endmodule

// File: rtl/oca_chk.sv
module oca_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             out_valid,
    input logic [WIDTH-1:0] sum,
    input logic             pos_zero,
    input logic             neg_zero
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) == out_valid);

    // R5
    pos_zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_zero) |-> ($past(op_a) == '0 && $past(op_b) == '0));

    // R6
    pz_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_zero |-> (sum == '0));

    // R6
    nz_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg_zero |-> (sum == '1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(sum) && $stable(pos_zero) && $stable(neg_zero)));

    // R3
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_b == ~op_a)) |=> (sum == '1 && neg_zero));
endmodule

bind ones_comp_adder oca_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .sum       (sum),
    .pos_zero  (pos_zero),
    .neg_zero  (neg_zero)
);

// File: tb/ones_comp_adder_tb.sv
module ones_comp_adder_tb;
    localparam int unsigned W = 16;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         out_valid;
    logic [W-1:0] sum;
    logic         pos_zero;
    logic         neg_zero;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit monitor_on = 1'b0;
    bit have_last = 1'b0;
    logic [W-1:0] last_sum;
    logic last_pz, last_nz;

    typedef struct {
        logic [W-1:0] val;
        logic         pz;
        logic         nz;
        int           cyc;
        string        tag;
    } exp_t;

    exp_t q[$];

    ones_comp_adder #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .sum(sum), .pos_zero(pos_zero), .neg_zero(neg_zero)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference: repeatedly fold carries in a wide integer
    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y);
        longint unsigned s;
        s = longint'(x) + longint'(y);
        while (s > longint'(ONES)) s = (s & longint'(ONES)) + (s >> W);
        return s[W-1:0];
    endfunction

    task automatic send(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = x;
        op_b = y;
        in_valid = 1'b1;
        e.val = ref_sum(x, y);
        e.pz  = (e.val == '0);
        e.nz  = (e.val == ONES);
        e.cyc = cyc + 1;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = W'($urandom);
            op_b = W'($urandom);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (monitor_on && rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.cyc, "R2", "result cycle", cyc, e.cyc);
                    check(sum == e.val, e.tag, "sum", sum, e.val);
                    check(pos_zero == e.pz, "R6", "pos_zero", pos_zero, e.pz);
                    check(neg_zero == e.nz, "R6", "neg_zero", neg_zero, e.nz);
                    last_sum = e.val;
                    last_pz  = e.pz;
                    last_nz  = e.nz;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check(sum == last_sum, "R7", "held sum", sum, last_sum);
                check({pos_zero, neg_zero} == {last_pz, last_nz}, "R7", "held flags",
                      {pos_zero, neg_zero}, {last_pz, last_nz});
            end
        end
    end

    task automatic reset_check();
        check(sum == '0, "R8", "sum in reset", sum, 0);
        check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
        check({pos_zero, neg_zero} == 2'b00, "R8", "flags in reset", {pos_zero, neg_zero}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        @(negedge clk);
        reset_check();
        monitor_on = 1'b1;

        // Corner cases
        send('0, '0, "R5");
        send(ONES, ONES, "R4");
        send(16'h1234, ~16'h1234, "R3");
        send(16'h0000, ONES, "R3");
        send(16'h8000, 16'h8000, "R1");
        send(ONES, 16'h0001, "R4");
        send(ONES, 16'h5A5A, "R4");
        send(16'h7FFF, 16'h0001, "R1");
        send(16'hFFFE, 16'h0001, "R5");
        idle(3);
        send(16'h0001, 16'hFFFE, "R5");
        idle(1);
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] v;
            v = W'($urandom);
            send(v, ~v, "R3");
        end
        idle(2);

        // Random traffic with gaps
        for (int i = 0; i < 300; i++) begin
            send(W'($urandom), W'($urandom), "R1");
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
        end
        idle(4);
        check(q.size() == 0, "R2", "pending results", q.size(), 0);

        // Mid-run reset
        send(16'hABCD, 16'h1111, "R1");
        @(negedge clk);
        in_valid = 1'b0;
        monitor_on = 1'b0;
        rst_n = 1'b0;
        q.delete();
        have_last = 1'b0;
        @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        @(negedge clk);
        monitor_on = 1'b1;
        send('0, '0, "R5");
        send(ONES, ONES, "R4");
        idle(3);
        check(q.size() == 0, "R2", "pending results after reset", q.size(), 0);
        finish_run();
    end
endmodule